// File: doc/BRIEF.md
# Sparse Frequency-Domain Subcarrier Filter

This block shapes each subcarrier of a multicarrier transmitter in the frequency domain. Its input is a stream of M frequency bins for each subcarrier, sent one subcarrier after another. Each subcarrier's pulse reaches into its neighbour, so every output bin is the sum of two products. The first is the current subcarrier's bin times a rising-edge coefficient. The second is the same bin of the preceding subcarrier times a falling-edge coefficient. Once all K subcarriers of a block have been streamed, the output holds K·M bins in natural spectral order, ready for an inverse transform.

The previous subcarrier's bins are kept in a history store indexed by bin, which acts as an M-deep delay line. M is set at run time through `cfg_m_minus1`. A block start marker resets the bin position. It also makes the block's first subcarrier see an all-zero neighbour. A per-sample activity flag zeroes the data of switched-off subcarriers before they are filtered and before they are stored. Software loads the two coefficient tables through a simple write port.

Top module: `sc_halfband_shaper`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high in cycle n+3 exactly when `in_valid` was high in cycle n. In a cycle with `out_valid` low, `out_data` keeps its previous value.
- R3: Samples and coefficients are complex, with the in-phase part as signed 16 bits in [31:16] and the quadrature part as signed 16 bits in [15:0]. Coefficients have 14 fractional bits, so 16384 is 1.0. The output for bin m is the complex sum x·rise[m] + p·fall[m], rounded and saturated as R7 gives.
- R4: Valid samples are numbered bin 0 to M-1, with M = `cfg_m_minus1`+1, and the count wraps to 0 after bin M-1. The p used at bin m is the masked sample that entered at bin m of the preceding subcarrier.
- R5: A valid sample with `in_first`=1 is bin 0. For it, and for the rest of that subcarrier, p is zero. The first subcarrier after reset also uses p = 0.
- R6: A sample with `sc_active`=0 counts as zero, both as the current x and as the p seen by the next subcarrier.
- R7: Each component is computed as (sum + 2^13) arithmetically shifted right by 14, then clamped to the range [-32768, 32767].
- R8: `coef_we` writes `coef_data` to entry `coef_addr` of the rising table when `coef_sel`=0, or of the falling table when `coef_sel`=1. The new value applies to samples accepted on later clock edges.
- R9: Changing `cfg_m_minus1` while the input is idle changes the subcarrier length for the next block, from 1 (value 0) up to 16 (value 15).
- R10: Cycles with `in_valid`=0 neither advance the bin count nor change the stored history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_m_minus1 | input | 4 | Bins per subcarrier minus one |
| in_valid | input | 1 | Input sample qualifier |
| in_first | input | 1 | Marks the first sample of a block |
| sc_active | input | 1 | Subcarrier of this sample is switched on |
| in_data | input | 32 | Complex input bin, I in [31:16], Q in [15:0] |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 1 | 0 selects the rising table, 1 the falling table |
| coef_addr | input | 4 | Coefficient entry (bin index) |
| coef_data | input | 32 | Complex coefficient, I in [31:16], Q in [15:0] |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | 32 | Shaped complex bin, I in [31:16], Q in [15:0] |

## Verification
Suppose the bin counter slips or the first-subcarrier flag is wrong. Then a bin is paired with the wrong coefficient, or with a stale neighbour. The damage shows on `out_data` three cycles after the affected sample, and every later bin of that subcarrier is wrong as well. A history entry that was corrupted, or written on an idle cycle, stays hidden until the same bin of the next subcarrier. So the bench runs each block over at least two subcarriers and inserts gaps in the input. Rounding and saturation faults show only at the half-LSB and full-scale points, and directed vectors aim at those points.

// File: rtl/sc_halfband_shaper.sv
module sc_halfband_shaper #(
  parameter int MMAX = 16,
  parameter int DW   = 16,
  parameter int FRAC = 14,
  localparam int AW  = $clog2(MMAX),
  localparam int CW  = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_m_minus1,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          sc_active,
  input  logic [CW-1:0] in_data,
  input  logic          coef_we,
  input  logic          coef_sel,
  input  logic [AW-1:0] coef_addr,
  input  logic [CW-1:0] coef_data,
  output logic          out_valid,
  output logic [CW-1:0] out_data
);

  localparam int PW = 2 * DW + 1;
  localparam int SW = 2 * DW + 3;
  localparam logic signed [SW-1:0] RND  = {{(SW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [CW-1:0] rise_t [MMAX];
  logic [CW-1:0] fall_t [MMAX];
  logic [CW-1:0] hist   [MMAX];

  logic [AW-1:0] cnt;
  logic          fsc;

  logic [AW-1:0] idx;
  logic          first_now;
  logic [CW-1:0] xm;
  logic [CW-1:0] prev_rd;
  logic          wrap;

  assign idx       = in_first ? '0 : cnt;
  assign first_now = in_first | fsc;
  assign xm        = sc_active ? in_data : '0;
  assign prev_rd   = first_now ? '0 : hist[idx];
  assign wrap      = (idx == cfg_m_minus1);

  function automatic logic signed [PW-1:0] cm_re(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic signed [DW-1:0] ar, ai, br, bi;
    logic signed [PW-1:0] t0, t1;
    ar = a[CW-1:DW]; ai = a[DW-1:0];
    br = b[CW-1:DW]; bi = b[DW-1:0];
    t0 = ar * br;
    t1 = ai * bi;
    return t0 - t1;
  endfunction

  function automatic logic signed [PW-1:0] cm_im(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic signed [DW-1:0] ar, ai, br, bi;
    logic signed [PW-1:0] t0, t1;
    ar = a[CW-1:DW]; ai = a[DW-1:0];
    br = b[CW-1:DW]; bi = b[DW-1:0];
    t0 = ar * bi;
    t1 = ai * br;
    return t0 + t1;
  endfunction

  function automatic logic [DW-1:0] rnd_sat(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] t;
    t = (s + RND) >>> FRAC;
    if (t > MAXV)      return MAXV[DW-1:0];
    else if (t < MINV) return MINV[DW-1:0];
    else               return t[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MMAX; i++) begin
        rise_t[i] <= '0;
        fall_t[i] <= '0;
      end
    end else if (coef_we) begin
      if (coef_sel) fall_t[coef_addr] <= coef_data;
      else          rise_t[coef_addr] <= coef_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      fsc <= 1'b1;
    end else if (in_valid) begin
      cnt <= wrap ? '0 : idx + 1'b1;
      fsc <= wrap ? 1'b0 : first_now;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) hist[idx] <= xm;
  end

  logic          v1;
  logic [CW-1:0] x1, p1, r1, f1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      x1 <= '0; p1 <= '0; r1 <= '0; f1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        x1 <= xm;
        p1 <= prev_rd;
        r1 <= rise_t[idx];
        f1 <= fall_t[idx];
      end
    end
  end

  logic                 v2;
  logic signed [PW-1:0] a_re, a_im, b_re, b_im;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      a_re <= '0; a_im <= '0; b_re <= '0; b_im <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        a_re <= cm_re(x1, r1);
        a_im <= cm_im(x1, r1);
        b_re <= cm_re(p1, f1);
        b_im <= cm_im(p1, f1);
      end
    end
  end

  logic signed [SW-1:0] s_re, s_im;
  always_comb begin
    s_re = a_re;
    s_re = s_re + b_re;
    s_im = a_im;
    s_im = s_im + b_im;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= v2;
      if (v2) out_data <= {rnd_sat(s_re), rnd_sat(s_im)};
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && cfg_m_minus1 != '0) |=> (cnt == 1));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_first && cnt == cfg_m_minus1) |=> (cnt == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt));

endmodule

// File: tb/tb_sc_halfband_shaper.sv
module tb_sc_halfband_shaper;
  localparam int MMAX = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_m_minus1 = 4'd3;
  logic        in_valid = 1'b0, in_first = 1'b0, sc_active = 1'b1;
  logic [31:0] in_data = '0;
  logic        coef_we = 1'b0, coef_sel = 1'b0;
  logic [3:0]  coef_addr = '0;
  logic [31:0] coef_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  sc_halfband_shaper dut (
    .clk(clk), .rst_n(rst_n), .cfg_m_minus1(cfg_m_minus1),
    .in_valid(in_valid), .in_first(in_first), .sc_active(sc_active), .in_data(in_data),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];

  int          m_cnt = 0, mcfg = 3;
  bit          m_first = 1'b1;
  logic [31:0] m_hist [MMAX];
  logic [31:0] m_rise [MMAX];
  logic [31:0] m_fall [MMAX];

  function automatic logic [31:0] pk(input int i, input int q);
    logic [31:0] r;
    r = {i[15:0], q[15:0]};
    return r;
  endfunction

  function automatic logic [15:0] rs(input longint s);
    longint t;
    t = (s + 64'sd8192) >>> 14;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t[15:0];
  endfunction

  function automatic logic [31:0] calc(input logic [31:0] x, p, r, f);
    longint xr, xi, pr, pi, rr, ri, fr, fi, sre, sim;
    xr = $signed(x[31:16]); xi = $signed(x[15:0]);
    pr = $signed(p[31:16]); pi = $signed(p[15:0]);
    rr = $signed(r[31:16]); ri = $signed(r[15:0]);
    fr = $signed(f[31:16]); fi = $signed(f[15:0]);
    sre = xr*rr - xi*ri + pr*fr - pi*fi;
    sim = xr*ri + xi*rr + pr*fi + pi*fr;
    return {rs(sre), rs(sim)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d, input bit act, input bit first, input string tag);
    int idx; bit f; logic [31:0] x, p;
    @(posedge clk); #1;
    in_valid = 1'b1; in_first = first; sc_active = act; in_data = d;
    idx = first ? 0 : m_cnt;
    f = first | m_first;
    x = act ? d : 32'h0;
    p = f ? 32'h0 : m_hist[idx];
    exp_q.push_back(calc(x, p, m_rise[idx], m_fall[idx]));
    cyc_q.push_back(cyc + 3);
    tag_q.push_back(tag);
    m_hist[idx] = x;
    if (idx == mcfg) begin m_cnt = 0; m_first = 1'b0; end
    else begin m_cnt = idx + 1; m_first = f; end
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    in_valid = 1'b0; in_first = 1'b0; in_data = 32'hDEAD_BEEF;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic drain(input string tag);
    idle(6);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic set_coef(input bit sel, input int addr, input logic [31:0] v);
    @(posedge clk); #1;
    coef_we = 1'b1; coef_sel = sel; coef_addr = addr[3:0]; coef_data = v;
    if (sel) m_fall[addr] = v; else m_rise[addr] = v;
    @(posedge clk); #1;
    coef_we = 1'b0;
  endtask

  task automatic set_m(input int m1);
    @(posedge clk); #1;
    cfg_m_minus1 = m1[3:0]; mcfg = m1;
  endtask

  logic [31:0] last_out = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected output", out_data, 32'h0);
        end else begin
          logic [31:0] e; int ec; string t;
          e = exp_q.pop_front(); ec = cyc_q.pop_front(); t = tag_q.pop_front();
          chk(out_data == e, t, out_data, e);
          chk(cyc == ec, "R2 latency", cyc, ec);
        end
      end else if (out_data != last_out) begin
        chk(1'b0, "R2 hold", out_data, last_out);
      end
      last_out = out_data;
    end
  end

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", {31'b0, out_valid}, 0);
    chk(out_data == 32'h0, "R1 data", out_data, 0);
  endtask

  task automatic t_passthru();
    for (int i = 0; i < 4; i++) begin
      set_coef(0, i, pk(16384, 0));
      set_coef(1, i, pk(0, 0));
    end
    set_m(3);
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 4; i++)
        send(pk(100*i - 250 + s*37, -77*i + 5), 1'b1, (s == 0 && i == 0), "R3 passthru");
    drain("R3 drain");
  endtask

  task automatic t_overlap();
    for (int i = 0; i < 4; i++) begin
      set_coef(0, i, pk(4000 + 700*i, -300*i));
      set_coef(1, i, pk(9000 - 1100*i, 250*i + 40));
    end
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 4; i++)
        send(pk(1234*s - 900*i + 17, 311*i - 2000*s), 1'b1, (s == 0 && i == 0), "R4 overlap");
    for (int i = 0; i < 4; i++)
      send(pk(-5000 + 10*i, 4444), 1'b1, (i == 0), "R5 block start");
    drain("R4 drain");
  endtask

  task automatic t_mask();
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 4; i++)
        send(pk(3000 + i*11, -2500 + s*99), (s != 1), (s == 0 && i == 0), "R6 inactive");
    drain("R6 drain");
  endtask

  task automatic t_round_sat();
    for (int i = 0; i < 4; i++) begin
      set_coef(0, i, pk(32767, 32767));
      set_coef(1, i, pk(-32768, 32767));
    end
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 4; i++)
        send(pk(i[0] ? -32768 : 32767, i[1] ? 32767 : -32768), 1'b1, (s == 0 && i == 0), "R7 saturate");
    drain("R7 drain sat");
    for (int i = 0; i < 4; i++) begin
      set_coef(0, i, pk(8192, 0));
      set_coef(1, i, pk(0, 0));
    end
    send(pk(1, -1), 1'b1, 1'b1, "R7 half round");
    send(pk(3, -3), 1'b1, 1'b0, "R7 half round");
    send(pk(-5, 5), 1'b1, 1'b0, "R7 half round");
    send(pk(2, 7), 1'b1, 1'b0, "R7 half round");
    drain("R7 drain rnd");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 4; i++) begin
      set_coef(0, i, pk(12000 - 500*i, 1500));
      set_coef(1, i, pk(6000, -900 + 400*i));
    end
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 4; i++) begin
        send(pk(700*i + 13*s, -800 + 321*s), 1'b1, (s == 0 && i == 0), "R10 gaps");
        if ((i + s) % 2 == 0) idle(1 + i);
      end
    drain("R10 drain");
  endtask

  task automatic t_mlen();
    set_m(0);
    for (int s = 0; s < 4; s++)
      send(pk(1000 + 500*s, -400*s), 1'b1, (s == 0), "R9 M=1");
    drain("R9 drain 1");
    for (int i = 0; i < MMAX; i++) begin
      set_coef(0, i, pk(2000 + 600*i, 100*i));
      set_coef(1, i, pk(15000 - 700*i, -50*i));
    end
    set_m(15);
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < MMAX; i++)
        send(pk(50*i - 300 + s*1000, 900 - 60*i), 1'b1, (s == 0 && i == 0), "R9 M=16");
    drain("R9 drain 16");
    set_m(3);
  endtask

  task automatic t_reload();
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 4; i++)
        send(pk(2222 - 100*i, 1111 + 30*s), 1'b1, (s == 0 && i == 0), "R8 before reload");
    drain("R8 drain a");
    set_coef(0, 2, pk(-16384, 8000));
    set_coef(1, 1, pk(3000, -12000));
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 4; i++)
        send(pk(2222 - 100*i, 1111 + 30*s), 1'b1, (s == 0 && i == 0), "R8 after reload");
    drain("R8 drain b");
  endtask

  task automatic t_restart();
    for (int i = 0; i < 6; i++)
      send(pk(400*i - 1000, 123*i), 1'b1, (i == 0), "R5 pre restart");
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 4; i++)
        send(pk(-700 + 222*i, 3000 - 333*s), 1'b1, (s == 0 && i == 0), "R5 mid restart");
    drain("R5 drain");
  endtask

  initial begin
    for (int i = 0; i < MMAX; i++) begin
      m_rise[i] = '0; m_fall[i] = '0; m_hist[i] = '0;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_passthru();
    t_overlap();
    t_mask();
    t_round_sat();
    t_gaps();
    t_mlen();
    t_reload();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule